// File: doc/BRIEF.md
# USB OTG Interrupt Aggregator with End-of-Interrupt Gating

This block sits between a USB OTG controller core and a CPU. It gathers the controller's per-endpoint transmit and receive event pulses, its core USB event pulses and any change on the drive-VBUS level into one latched 32-bit source word. Software reads the word through a small word-addressed register file. It can force bits with a write-one-to-set alias and acknowledge them with a write-one-to-clear alias. A mask with its own set and clear aliases gates which sources reach the CPU.

The CPU sees a single interrupt line. The line pulses for one cycle when any unmasked source bit is set and the block is armed. The block then stays disarmed until software writes any value to the end-of-interrupt register. A control register holds a soft-reset bit that clears the block and is also driven out to the controller. A read-only revision constant and a status register showing the live drive-VBUS level complete the map.

Top module: `usb_irq_wrap`

## Requirements
- R1: Reading byte offset 0x00 returns the nonzero constant REV_ID (default 32'h4EA1_0001).
- R2: Hardware event pulses latch into the raw source word at offset 0x20. Transmit events go to bits 4:0, receive events to bits 12:9, core events to bits 23:16, and a change of either polarity on the drive-VBUS input sets bit 24. Bit 8 and all other bits always read 0.
- R3: A write to 0x24 sets every source bit written as one. Reads of 0x24, 0x28, 0x30, 0x34, 0x3C and any unmapped offset return 0.
- R4: A write to 0x28 clears every source bit written as one, and zero bits have no effect. A hardware event in the same cycle as the clear leaves its bit set.
- R5: Writes to 0x30 set mask bits and writes to 0x34 clear them, one bit for one bit. The mask reads at 0x2C, and writes to 0x2C or 0x20 change nothing.
- R6: Offset 0x38 reads the raw source ANDed with the mask.
- R7: irq_o is high for exactly one cycle when the masked source is nonzero and the block is armed. It stays low after that until a write of any value to 0x3C re-arms the block.
- R8: Writing 1 to bit 0 of control (0x04) makes the bit read 1 and soft_rst_o high for the next cycle. After that cycle the source, mask and control read 0 and the block is armed.
- R9: Offset 0x08 bit 0 reads the current drive-VBUS input level.
- R10: After hardware reset all registers read 0 except revision, the block is armed, and irq_o and soft_rst_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tx_evt_i | input | N_TX | Transmit endpoint event pulses |
| rx_evt_i | input | N_RX | Receive endpoint event pulses |
| core_evt_i | input | N_CORE | Core USB event pulses |
| drvvbus_i | input | 1 | Drive-VBUS level from the core |
| irq_o | output | 1 | Interrupt pulse to the CPU |
| soft_rst_o | output | 1 | Soft reset to the controller |

## Verification
The bench first drives each event group alone, then several at once, so that a wrong bit position or a lane crossing shows up in the raw word. Software sets and clears are tried with all-ones data, with all-zero data and in the same cycle as a hardware event. This separates write-one semantics from plain writes and shows which side has priority. A partial mask with a steady source separates the one-shot line from a level output. A second assertion after the end-of-interrupt write shows that re-arming works. Rising and falling drive-VBUS edges, followed by a soft reset with events pending, cover the edge detector and the clearing path.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam logic [7:0] OFS_REV    = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_STAT   = 8'h08;
  localparam logic [7:0] OFS_SRC    = 8'h20;
  localparam logic [7:0] OFS_SSET   = 8'h24;
  localparam logic [7:0] OFS_SCLR   = 8'h28;
  localparam logic [7:0] OFS_MASK   = 8'h2C;
  localparam logic [7:0] OFS_MSET   = 8'h30;
  localparam logic [7:0] OFS_MCLR   = 8'h34;
  localparam logic [7:0] OFS_MASKED = 8'h38;
  localparam logic [7:0] OFS_EOI    = 8'h3C;
  localparam int TX_LSB   = 0;
  localparam int RX_BASE  = 8;   // receive endpoint 0 slot, never set
  localparam int CORE_LSB = 16;
  localparam int WORD_W   = 32;
endpackage

// File: rtl/irqw_w1sc_reg.sv
module irqw_w1sc_reg #(
  parameter int          W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (srst_i) q_q <= '0;
    else             q_q <= (((q_q | set_i) & ~clr_i) | evt_i) & VALID;
  end

  assign q_o = q_q;

  assert_evt_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && ((evt_i & VALID) != '0)) |=> ((q_q & $past(evt_i & VALID)) == $past(evt_i & VALID)));

  // write-one-to-clear for source (R4) and mask (R5)
  assert_w1c_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && ((clr_i & ~evt_i) != '0)) |=> ((q_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/irqw_eoi_gate.sv
module irqw_eoi_gate #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         eoi_i,
  input  logic [W-1:0] masked_i,
  output logic         irq_o
);
  logic armed_q;

  assign irq_o = armed_q & (|masked_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              armed_q <= 1'b1;
    else if (srst_i || eoi_i) armed_q <= 1'b1;
    else if (irq_o)           armed_q <= 1'b0;
  end

  assert_one_shot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !eoi_i && !srst_i) |=> !irq_o);

  assert_needs_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (masked_i != '0));

  assert_stay_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !eoi_i && !srst_i) |=> !irq_o);
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import irqw_pkg::*;
#(
  parameter int          N_TX   = 5,
  parameter int          N_RX   = 4,
  parameter int          N_CORE = 8,
  parameter logic [31:0] REV_ID = 32'h4EA1_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_TX-1:0]   tx_evt_i,
  input  logic [N_RX-1:0]   rx_evt_i,
  input  logic [N_CORE-1:0] core_evt_i,
  input  logic              drvvbus_i,
  output logic              irq_o,
  output logic              soft_rst_o
);
  localparam int RX_LSB  = RX_BASE + 1;
  localparam int DRV_BIT = CORE_LSB + N_CORE;
  localparam logic [WORD_W-1:0] VALID =
      ((((WORD_W)'(1) << N_TX) - 1) << TX_LSB) |
      ((((WORD_W)'(1) << N_RX) - 1) << RX_LSB) |
      ((((WORD_W)'(1) << N_CORE) - 1) << CORE_LSB) |
      ((WORD_W)'(1) << DRV_BIT);

  logic              ctrl_q, drv_q, srst;
  logic [WORD_W-1:0] evt, src, mask, masked;
  logic [WORD_W-1:0] src_set, src_clr, msk_set, msk_clr;
  logic              eoi_wr;

  assign srst       = ctrl_q;
  assign soft_rst_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      drv_q <= drvvbus_i;
      if (srst)                                ctrl_q <= 1'b0;
      else if (wr_en_i && addr_i == OFS_CTRL)  ctrl_q <= wdata_i[0];
    end
  end

  always_comb begin
    evt = '0;
    evt[TX_LSB +: N_TX]     = tx_evt_i;
    evt[RX_LSB +: N_RX]     = rx_evt_i;
    evt[CORE_LSB +: N_CORE] = core_evt_i;
    evt[DRV_BIT]            = drvvbus_i ^ drv_q;
  end

  assign src_set = (wr_en_i && addr_i == OFS_SSET) ? wdata_i : '0;
  assign src_clr = (wr_en_i && addr_i == OFS_SCLR) ? wdata_i : '0;
  assign msk_set = (wr_en_i && addr_i == OFS_MSET) ? wdata_i : '0;
  assign msk_clr = (wr_en_i && addr_i == OFS_MCLR) ? wdata_i : '0;
  assign eoi_wr  = wr_en_i && addr_i == OFS_EOI;

  irqw_w1sc_reg #(.W(WORD_W), .VALID(VALID)) u_src (
    .clk_i, .rst_ni, .srst_i(srst),
    .set_i(src_set), .clr_i(src_clr), .evt_i(evt), .q_o(src)
  );

  irqw_w1sc_reg #(.W(WORD_W), .VALID(VALID)) u_mask (
    .clk_i, .rst_ni, .srst_i(srst),
    .set_i(msk_set), .clr_i(msk_clr), .evt_i('0), .q_o(mask)
  );

  assign masked = src & mask;

  irqw_eoi_gate #(.W(WORD_W)) u_eoi (
    .clk_i, .rst_ni, .srst_i(srst), .eoi_i(eoi_wr),
    .masked_i(masked), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      OFS_REV:    rdata_o = REV_ID;
      OFS_CTRL:   rdata_o = {31'b0, ctrl_q};
      OFS_STAT:   rdata_o = {31'b0, drvvbus_i};
      OFS_SRC:    rdata_o = src;
      OFS_MASK:   rdata_o = mask;
      OFS_MASKED: rdata_o = masked;
      default:    rdata_o = '0;
    endcase
  end

  assert_srst_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (src == '0 && mask == '0 && !soft_rst_o));

  assert_no_stray_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o != '0 && addr_i == OFS_SRC) |-> ((rdata_o & ~VALID) == '0));

  assert_drv_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drvvbus_i != drv_q && !srst) |=> src[DRV_BIT]);
endmodule

// File: tb/sim_usb_irq_wrap.sv
module sim_usb_irq_wrap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [4:0]  tx = '0;
  logic [3:0]  rx = '0;
  logic [7:0]  core = '0;
  logic        vb = 1'b0;
  logic        irq, srst_o;

  localparam logic [31:0] REV   = 32'h4EA1_0001;
  localparam logic [31:0] VALID = 32'h01FF_1E1F;

  int checks = 0, errors = 0;
  logic [31:0] m_src = '0, m_mask = '0;
  bit m_ctrl = 0, m_armed = 1, m_vbq = 0;
  string ovr = "";

  always #10 clk = ~clk;

  usb_irq_wrap u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wd),
    .rdata_o(rdata), .tx_evt_i(tx), .rx_evt_i(rx), .core_evt_i(core),
    .drvvbus_i(vb), .irq_o(irq), .soft_rst_o(srst_o)
  );

  task automatic ck(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string addr_tag(logic [7:0] a);
    case (a)
      8'h00: return "R1";
      8'h04: return "R8";
      8'h08: return "R9";
      8'h20: return "R2";
      8'h2C: return "R5";
      8'h38: return "R6";
      default: return "R3";
    endcase
  endfunction

  // one clock: drive, compare against model, then advance model
  task automatic cyc(logic [7:0] a, bit w, logic [31:0] d,
                     logic [4:0] t, logic [3:0] r, logic [7:0] c);
    logic [31:0] msk, exp_rd, evt, sset, sclr, mset, mclr;
    bit exp_irq;
    @(negedge clk);
    addr = a; we = w; wd = d; tx = t; rx = r; core = c;
    #2;
    msk = m_src & m_mask;
    exp_irq = m_armed && (msk != 0);
    case (a)
      8'h00: exp_rd = REV;
      8'h04: exp_rd = {31'b0, m_ctrl};
      8'h08: exp_rd = {31'b0, vb};
      8'h20: exp_rd = m_src;
      8'h2C: exp_rd = m_mask;
      8'h38: exp_rd = msk;
      default: exp_rd = 0;
    endcase
    ck(rdata === exp_rd, (ovr != "") ? ovr : addr_tag(a), rdata, exp_rd);
    ck(irq === exp_irq, (ovr != "") ? ovr : "R7", {31'b0, irq}, {31'b0, exp_irq});
    ck(srst_o === m_ctrl, (ovr != "") ? ovr : "R8", {31'b0, srst_o}, {31'b0, m_ctrl});
    @(posedge clk);
    if (m_ctrl) begin
      m_src = 0; m_mask = 0; m_ctrl = 0; m_armed = 1;
    end else begin
      evt  = {7'b0, vb ^ m_vbq, c, 3'b0, r, 4'b0, t};
      sset = (w && a == 8'h24) ? d : 0;
      sclr = (w && a == 8'h28) ? d : 0;
      mset = (w && a == 8'h30) ? d : 0;
      mclr = (w && a == 8'h34) ? d : 0;
      m_src  = (((m_src | sset) & ~sclr) | evt) & VALID;
      m_mask = ((m_mask | mset) & ~mclr) & VALID;
      if (w && a == 8'h3C) m_armed = 1;
      else if (exp_irq)    m_armed = 0;
      if (w && a == 8'h04) m_ctrl = d[0];
    end
    m_vbq = vb;
  endtask

  task automatic rd(logic [7:0] a);
    cyc(a, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(a, 1, d, 0, 0, 0);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10 reset state
    ovr = "R10";
    foreach (u0.rdata_o[i]) ;
    rd(8'h04); rd(8'h20); rd(8'h2C); rd(8'h38);
    ovr = "";
    rd(8'h00);                                   // R1
    // R2 per-group events
    cyc(8'h20, 0, 0, 5'h1F, 0, 0);
    rd(8'h20);
    wr(8'h28, 32'hFFFF_FFFF);
    cyc(8'h20, 0, 0, 0, 4'hF, 0);
    rd(8'h20);
    cyc(8'h20, 0, 0, 0, 0, 8'hA5);
    rd(8'h20);
    cyc(8'h20, 0, 0, 5'h05, 4'h9, 8'h3C);
    rd(8'h20);
    // R9 drive-VBUS rise and fall
    vb = 1; rd(8'h08); rd(8'h20);
    wr(8'h28, 32'h0100_0000); rd(8'h20);
    vb = 0; rd(8'h08); rd(8'h20);
    // R4 clear zeros, clear all, clear with concurrent event
    wr(8'h28, 32'h0); rd(8'h20);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h20);
    cyc(8'h28, 1, 32'hFFFF_FFFF, 5'h02, 4'h4, 8'h80); rd(8'h20);
    wr(8'h28, 32'hFFFF_FFFF);
    // R3 force all bits; bit 8 stays 0
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h20);
    rd(8'h24); rd(8'h28); rd(8'h30); rd(8'h34); rd(8'h3C); rd(8'h10);
    // R5 direct writes ignored
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C);
    wr(8'h20, 32'h0); rd(8'h20);
    wr(8'h28, 32'hFFFF_FFFF);
    // R7 one-shot with partial mask
    wr(8'h30, 32'h0001_0003); rd(8'h2C);
    cyc(8'h38, 0, 0, 0, 0, 8'h01);
    for (int i = 0; i < 4; i++) rd(8'h38);       // R6 view, no refire
    cyc(8'h38, 0, 0, 5'h01, 0, 0);               // more sources, still disarmed
    rd(8'h38);
    wr(8'h3C, 32'h0);                            // EOI re-arms
    rd(8'h38); rd(8'h38);
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h3C, 32'h1234);
    cyc(8'h38, 0, 0, 5'h10, 0, 0);               // unmasked bit: no irq
    rd(8'h38);
    wr(8'h34, 32'h0000_0001); rd(8'h2C);          // R5 mask clear
    wr(8'h24, 32'h0000_0002); rd(8'h38); rd(8'h38);
    // R8 soft reset with sources pending
    wr(8'h24, 32'h00FF_0000); wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h04, 32'h1); rd(8'h04);
    rd(8'h20); rd(8'h2C); rd(8'h04);
    wr(8'h24, 32'h0000_0001); wr(8'h30, 32'h1); rd(8'h38); rd(8'h38);
    wr(8'h04, 32'h0); rd(8'h04);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule